// File: doc/BRIEF.md
# Dual-Bank Flash Command Sequencer

This block sits behind the bus interface of a flash-style memory that is split into two banks. It watches every bus write, matches the writes against the unlock-prefixed command sequences, and turns a completed sequence into a one-cycle program or erase request with the target address. Each bank keeps its own mode register: array read, identification read, programming, erasing, erase-suspended, or programming while an erase is suspended. Only the addressed bank changes mode, so a read of the idle bank returns array data while the other bank is busy, with no added cycles.

A read address is decoded combinationally into a read-source selector, which the datapath uses to choose between the array, the identification register and a status word. Cell timing is modelled by a down-counter in each bank, loaded with a parameterised count when an operation starts. An accelerate input forces the short program path, overrides sector protection and loads a shorter program count.

Top module: `flash_cmd_fsm`

## Requirements
- R1: After reset both banks are in array read mode (`rd_src` = 0 for any address), `bank_busy` = 0, `bypass_on` = 0, and no command is needed before array reads.
- R2: The bank is selected by the top address bit (0 = bank with small sectors of 2^SMALL_SEC_W words, 1 = bank with large sectors of 2^LARGE_SEC_W words); `erase_addr` is the sector base, the address with the in-sector bits cleared.
- R3: The normal program sequence is four writes: (offset 0x555, 0xAA), (offset 0x2AA, 0x55), (offset 0x555, 0xA0), (target, data); offset means the address bits below the bank bit. It raises `prog_req` for one cycle with the target and data, and the target bank reads as busy for exactly PROG_CYC cycles.
- R4: Unlock plus (offset 0x555, 0x20) enters bypass mode (`bypass_on` = 1); there a program takes two writes, (any, 0xA0) then (target, data). Writes (any, 0x90) then (any, 0x00) leave bypass mode.
- R5: While `acc` is high, `bypass_on` is 1, a write with `wr_prot` = 1 is still programmed, and the bank stays busy ACC_CYC cycles; with `acc` low a program or erase whose write carries `wr_prot` = 1 is ignored.
- R6: Unlock, (offset 0x555, 0x80), unlock, then (sector address, 0x30) erases one sector and keeps that bank busy ERASE_CYC cycles; ending with (offset 0x555, 0x10) instead erases the whole device, raising `erase_chip` and making both banks busy.
- R7: `rd_src` codes: 0 array, 1 identification, 2 status. Reads of a bank that is not busy return array data while the other bank programs or erases; reads of a busy bank return status.
- R8: Unlock plus (bank address with offset 0x555, 0x90) puts only that bank in identification mode.
- R9: A program or erase whose target bank is busy or in identification mode is ignored.
- R10: A write that does not match the next expected cycle of a sequence abandons it; the banks stay in their mode and no request is issued.
- R11: A write of 0xF0 returns banks in identification mode to array read and leaves bypass mode; it is ignored while either bank is programming or erasing.
- R12: A write of 0xB0 to an erasing bank suspends a sector erase: the bank is not busy, reads of the erasing sector return status and of other sectors array data, a program to another sector of that bank is accepted and one to the erasing sector ignored; 0x30 resumes the erase with its remaining count. Suspend has no effect during a whole-device erase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data; command codes on the low 8 bits |
| wr_prot | input | 1 | The sector addressed by this write is protected |
| acc | input | 1 | Accelerate: forces bypass, overrides protection, short program count |
| rd_addr | input | ADDR_W | Address of the current read |
| rd_src | output | 2 | Read source for `rd_addr`: 0 array, 1 identification, 2 status |
| bank_busy | output | 2 | Per bank: program or erase in progress |
| bypass_on | output | 1 | Short program path active |
| prog_req | output | 1 | One-cycle program request |
| prog_addr | output | ADDR_W | Program target address |
| prog_data | output | DATA_W | Program data |
| erase_req | output | 1 | One-cycle erase request |
| erase_chip | output | 1 | Whole-device erase in progress |
| erase_addr | output | ADDR_W | Base address of the sector to erase |

## Verification
The bench builds the block with a 12-bit address, 64-word and 512-word sectors, and counts of 8 (program), 3 (accelerated program) and 20 (erase). These short counts let each operation's exact busy window, an erase suspended part way, a program nested inside the suspension and the resumed remainder all be observed within a few dozen cycles. The 12-bit space lets random addresses land in both banks and in both sector sizes, so random reads during busy windows and random non-command writes cover the bank split and the sequence abort path.

// File: rtl/fcsm_pkg.sv
package fcsm_pkg;

    typedef enum logic [2:0] {
        BM_READ      = 3'd0,
        BM_IDENT     = 3'd1,
        BM_PROG      = 3'd2,
        BM_ERASE     = 3'd3,
        BM_SUSP      = 3'd4,
        BM_SUSP_PROG = 3'd5
    } bank_mode_e;

    typedef enum logic [2:0] {
        BC_NONE, BC_IDENT, BC_READ, BC_PROG, BC_ERASE, BC_SUSP, BC_RESUME
    } bank_cmd_e;

    typedef enum logic [3:0] {
        SQ_IDLE, SQ_U1, SQ_U2, SQ_PROG, SQ_E0, SQ_E1, SQ_E2, SQ_BPROG, SQ_BEXIT
    } seq_e;

    typedef enum logic [1:0] {
        SRC_ARRAY  = 2'd0,
        SRC_IDENT  = 2'd1,
        SRC_STATUS = 2'd2
    } rd_src_e;

    localparam logic [7:0] K_KEY_A    = 8'hAA;
    localparam logic [7:0] K_KEY_B    = 8'h55;
    localparam logic [7:0] K_PROGRAM  = 8'hA0;
    localparam logic [7:0] K_ERASE    = 8'h80;
    localparam logic [7:0] K_SECTOR   = 8'h30;
    localparam logic [7:0] K_WHOLE    = 8'h10;
    localparam logic [7:0] K_IDENT    = 8'h90;
    localparam logic [7:0] K_BYPASS   = 8'h20;
    localparam logic [7:0] K_SUSPEND  = 8'hB0;
    localparam logic [7:0] K_RESUME   = 8'h30;
    localparam logic [7:0] K_RESET    = 8'hF0;
    localparam logic [7:0] K_EXIT     = 8'h00;

    function automatic logic mode_busy(bank_mode_e m);
        return (m == BM_PROG) || (m == BM_ERASE) || (m == BM_SUSP_PROG);
    endfunction

endpackage

// File: rtl/fcsm_bank.sv
module fcsm_bank
    import fcsm_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bank_cmd_e         cmd_i,
    input  logic [CNT_W-1:0]  load_i,
    input  logic [ADDR_W-1:0] sec_i,
    output bank_mode_e        mode_o,
    output logic [ADDR_W-1:0] er_sec_o
);

    typedef struct packed {
        bank_mode_e        mode;
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  saved;
        logic [ADDR_W-1:0] er_sec;
    } bank_st_t;

    bank_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        case (st_q.mode)
            BM_READ: begin
                if (cmd_i == BC_IDENT) begin
                    st_d.mode = BM_IDENT;
                end else if (cmd_i == BC_PROG) begin
                    st_d.mode = BM_PROG;
                    st_d.cnt  = load_i;
                end else if (cmd_i == BC_ERASE) begin
                    st_d.mode   = BM_ERASE;
                    st_d.cnt    = load_i;
                    st_d.er_sec = sec_i;
                end
            end
            BM_IDENT: begin
                if (cmd_i == BC_READ) st_d.mode = BM_READ;
            end
            BM_PROG: begin
                if (st_q.cnt <= 1) begin
                    st_d.mode = BM_READ;
                    st_d.cnt  = '0;
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
            BM_ERASE: begin
                if (cmd_i == BC_SUSP) begin
                    st_d.mode  = BM_SUSP;
                    st_d.saved = st_q.cnt;
                    st_d.cnt   = '0;
                end else if (st_q.cnt <= 1) begin
                    st_d.mode = BM_READ;
                    st_d.cnt  = '0;
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
            BM_SUSP: begin
                if (cmd_i == BC_RESUME) begin
                    st_d.mode = BM_ERASE;
                    st_d.cnt  = st_q.saved;
                end else if (cmd_i == BC_PROG) begin
                    st_d.mode = BM_SUSP_PROG;
                    st_d.cnt  = load_i;
                end
            end
            BM_SUSP_PROG: begin
                if (st_q.cnt <= 1) begin
                    st_d.mode = BM_SUSP;
                    st_d.cnt  = '0;
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
            default: st_d.mode = BM_READ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mode_o   = st_q.mode;
    assign er_sec_o = st_q.er_sec;

    AST_PROG_FINISHES: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == BM_PROG && st_q.cnt == 1) |=> (st_q.mode == BM_READ)); // R3
    AST_BUSY_HAS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        mode_busy(st_q.mode) |-> (st_q.cnt != 0)); // R3
    AST_SUSP_KEEPS_REMAINDER: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == BM_SUSP && cmd_i == BC_NONE) |=> (st_q.mode == BM_SUSP && $stable(st_q.saved))); // R12

endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
    import fcsm_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int DATA_W      = 16,
    parameter int SMALL_SEC_W = 6,
    parameter int LARGE_SEC_W = 9,
    parameter int PROG_CYC    = 8,
    parameter int ACC_CYC     = 3,
    parameter int ERASE_CYC   = 20,
    parameter int KEY_ADDR_A  = 32'h555,
    parameter int KEY_ADDR_B  = 32'h2AA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_prot,
    input  logic              acc,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [1:0]        rd_src,
    output logic [1:0]        bank_busy,
    output logic              bypass_on,
    output logic              prog_req,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [DATA_W-1:0] prog_data,
    output logic              erase_req,
    output logic              erase_chip,
    output logic [ADDR_W-1:0] erase_addr
);

    localparam int NBANK   = 2;
    localparam int OFF_W   = ADDR_W - 1;
    localparam int MAX_CYC = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [OFF_W-1:0] OFF_A = OFF_W'(KEY_ADDR_A);
    localparam logic [OFF_W-1:0] OFF_B = OFF_W'(KEY_ADDR_B);

    typedef struct packed {
        seq_e              seq;
        logic              bypass;
        logic              chip;
        logic              prog_req;
        logic [ADDR_W-1:0] prog_addr;
        logic [DATA_W-1:0] prog_data;
        logic              erase_req;
        logic [ADDR_W-1:0] erase_addr;
    } top_st_t;

    function automatic logic [ADDR_W-1:0] sec_base(logic [ADDR_W-1:0] a);
        logic [ADDR_W-1:0] mask;
        mask = a[ADDR_W-1] ? ({ADDR_W{1'b1}} << LARGE_SEC_W)
                           : ({ADDR_W{1'b1}} << SMALL_SEC_W);
        return a & mask;
    endfunction

    top_st_t           st_d, st_q;
    bank_cmd_e         cmd   [NBANK];
    bank_mode_e        bmode [NBANK];
    logic [ADDR_W-1:0] er_sec [NBANK];
    logic [CNT_W-1:0]  load;

    // per-bank mode registers and timers
    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        fcsm_bank #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .cmd_i    (cmd[g]),
            .load_i   (load),
            .sec_i    (sec_base(wr_addr)),
            .mode_o   (bmode[g]),
            .er_sec_o (er_sec[g])
        );
        assign bank_busy[g] = mode_busy(bmode[g]);
    end

    // command sequence decoder
    always_comb begin
        logic       wb, byp, any_busy, allow_w;
        logic [7:0] code;
        logic [OFF_W-1:0] off;
        logic do_prog, do_serase, do_cerase, do_ident, do_reset, do_susp, do_resume;

        st_d           = st_q;
        st_d.prog_req  = 1'b0;
        st_d.erase_req = 1'b0;
        for (int b = 0; b < NBANK; b++) cmd[b] = BC_NONE;
        load      = CNT_W'(ERASE_CYC);
        wb        = wr_addr[ADDR_W-1];
        off       = wr_addr[OFF_W-1:0];
        code      = wr_data[7:0];
        byp       = st_q.bypass | acc;
        any_busy  = |bank_busy;
        allow_w   = !wr_prot || acc;
        do_prog   = 1'b0; do_serase = 1'b0; do_cerase = 1'b0; do_ident = 1'b0;
        do_reset  = 1'b0; do_susp   = 1'b0; do_resume = 1'b0;

        if (st_q.chip && !any_busy) st_d.chip = 1'b0;

        if (wr_en) begin
            st_d.seq = SQ_IDLE;
            case (st_q.seq)
                SQ_IDLE: begin
                    if (code == K_RESET)                        do_reset  = 1'b1;
                    else if (code == K_SUSPEND)                 do_susp   = 1'b1;
                    else if (code == K_RESUME)                  do_resume = 1'b1;
                    else if (byp && code == K_PROGRAM)          st_d.seq  = SQ_BPROG;
                    else if (st_q.bypass && !acc && code == K_IDENT) st_d.seq = SQ_BEXIT;
                    else if (!byp && off == OFF_A && code == K_KEY_A) st_d.seq = SQ_U1;
                end
                SQ_U1: if (off == OFF_B && code == K_KEY_B) st_d.seq = SQ_U2;
                SQ_U2: begin
                    if (off == OFF_A) begin
                        case (code)
                            K_PROGRAM: st_d.seq    = SQ_PROG;
                            K_ERASE:   st_d.seq    = SQ_E0;
                            K_IDENT:   do_ident    = 1'b1;
                            K_BYPASS:  st_d.bypass = 1'b1;
                            default:   ;
                        endcase
                    end
                end
                SQ_PROG, SQ_BPROG: do_prog = 1'b1;
                SQ_E0: if (off == OFF_A && code == K_KEY_A) st_d.seq = SQ_E1;
                SQ_E1: if (off == OFF_B && code == K_KEY_B) st_d.seq = SQ_E2;
                SQ_E2: begin
                    if (code == K_SECTOR)                      do_serase = 1'b1;
                    else if (off == OFF_A && code == K_WHOLE)  do_cerase = 1'b1;
                end
                SQ_BEXIT: if (code == K_EXIT) st_d.bypass = 1'b0;
                default: ;
            endcase
        end

        if (do_reset && !any_busy) begin
            st_d.bypass = 1'b0;
            for (int b = 0; b < NBANK; b++)
                if (bmode[b] == BM_IDENT) cmd[b] = BC_READ;
        end
        if (do_susp && !st_q.chip && bmode[wb] == BM_ERASE) cmd[wb] = BC_SUSP;
        if (do_resume && bmode[wb] == BM_SUSP)              cmd[wb] = BC_RESUME;
        if (do_ident && bmode[wb] == BM_READ)               cmd[wb] = BC_IDENT;
        if (do_prog && allow_w &&
            (bmode[wb] == BM_READ ||
             (bmode[wb] == BM_SUSP && sec_base(wr_addr) != er_sec[wb]))) begin
            cmd[wb]        = BC_PROG;
            load           = acc ? CNT_W'(ACC_CYC) : CNT_W'(PROG_CYC);
            st_d.prog_req  = 1'b1;
            st_d.prog_addr = wr_addr;
            st_d.prog_data = wr_data;
        end
        if (do_serase && allow_w && bmode[wb] == BM_READ) begin
            cmd[wb]         = BC_ERASE;
            st_d.erase_req  = 1'b1;
            st_d.erase_addr = sec_base(wr_addr);
        end
        if (do_cerase && bmode[0] == BM_READ && bmode[1] == BM_READ) begin
            for (int b = 0; b < NBANK; b++) cmd[b] = BC_ERASE;
            st_d.chip       = 1'b1;
            st_d.erase_req  = 1'b1;
            st_d.erase_addr = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // read source for the current read address
    always_comb begin
        logic rb;
        rb = rd_addr[ADDR_W-1];
        case (bmode[rb])
            BM_READ:  rd_src = SRC_ARRAY;
            BM_IDENT: rd_src = SRC_IDENT;
            BM_SUSP:  rd_src = (sec_base(rd_addr) == er_sec[rb]) ? SRC_STATUS : SRC_ARRAY;
            default:  rd_src = SRC_STATUS;
        endcase
    end

    assign bypass_on  = st_q.bypass | acc;
    assign prog_req   = st_q.prog_req;
    assign prog_addr  = st_q.prog_addr;
    assign prog_data  = st_q.prog_data;
    assign erase_req  = st_q.erase_req;
    assign erase_chip = st_q.chip;
    assign erase_addr = st_q.erase_addr;

    AST_PROG_TARGET_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req |-> bank_busy[prog_addr[ADDR_W-1]]); // R3
    AST_PROG_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req |=> !prog_req); // R4
    AST_SECTOR_TARGET_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_req && !erase_chip) |-> bank_busy[erase_addr[ADDR_W-1]]); // R6
    AST_WHOLE_BOTH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_req && erase_chip) |-> (&bank_busy)); // R6
    AST_IDENT_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_src == SRC_IDENT) |-> !bank_busy[rd_addr[ADDR_W-1]]); // R8

endmodule

// File: tb/flash_cmd_fsm_test.sv
module flash_cmd_fsm_test;

    localparam int AW = 12, DW = 16, SSW = 6, LSW = 9;
    localparam int PC = 8, AC = 3, EC = 20;
    localparam logic [AW-1:0] B1 = 12'h800;

    logic          clk = 1'b0, rst_n = 1'b0;
    logic          wr_en = 1'b0, wr_prot = 1'b0, acc = 1'b0;
    logic [AW-1:0] wr_addr = '0, rd_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [1:0]    rd_src, bank_busy;
    logic          bypass_on, prog_req, erase_req, erase_chip;
    logic [AW-1:0] prog_addr, erase_addr;
    logic [DW-1:0] prog_data;
    int nchk = 0, nfail = 0;

    always #4 clk = ~clk;

    flash_cmd_fsm #(.ADDR_W(AW), .DATA_W(DW), .SMALL_SEC_W(SSW), .LARGE_SEC_W(LSW),
                    .PROG_CYC(PC), .ACC_CYC(AC), .ERASE_CYC(EC)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_prot(wr_prot), .acc(acc), .rd_addr(rd_addr), .rd_src(rd_src),
        .bank_busy(bank_busy), .bypass_on(bypass_on), .prog_req(prog_req),
        .prog_addr(prog_addr), .prog_data(prog_data), .erase_req(erase_req),
        .erase_chip(erase_chip), .erase_addr(erase_addr));

    function automatic int exp_base(logic [AW-1:0] a);
        return a[AW-1] ? int'(a & ~12'h1FF) : int'(a & ~12'h03F);
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic p);
        wr_en = 1'b1; wr_addr = a; wr_data = d; wr_prot = p;
        @(negedge clk);
        wr_en = 1'b0; wr_prot = 1'b0;
    endtask

    task automatic unlock(input logic [AW-1:0] bank);
        wr(bank | 12'h555, 16'h00AA, 1'b0);
        wr(bank | 12'h2AA, 16'h0055, 1'b0);
    endtask

    task automatic program4(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic p);
        unlock(a & B1);
        wr((a & B1) | 12'h555, 16'h00A0, 1'b0);
        wr(a, d, p);
    endtask

    task automatic erase_seq(input logic [AW-1:0] a, input logic [7:0] last);
        unlock(a & B1);
        wr((a & B1) | 12'h555, 16'h0080, 1'b0);
        unlock(a & B1);
        wr(a, {8'h00, last}, 1'b0);
    endtask

    task automatic rd(input logic [AW-1:0] a, input int exp, input string req);
        rd_addr = a; #1;
        chk(req, "rd_src", int'(rd_src), exp);
    endtask

    task automatic wait_idle(input int limit);
        for (int i = 0; i < limit && bank_busy != 2'b00; i++) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("  %0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd(12'h000, 0, "R1"); rd(12'hFFF, 0, "R1");
        chk("R1", "bank_busy", int'(bank_busy), 0);
        chk("R1", "bypass_on", int'(bypass_on), 0);
        chk("R1", "prog_req", int'(prog_req), 0);

        // R10: random non-command writes never start an operation
        for (int i = 0; i < 24; i++) begin
            logic [AW-1:0] a; logic [DW-1:0] d;
            a = AW'($urandom); d = DW'($urandom);
            if (d[7:0] == 8'hAA) d[7:0] = 8'h3C;
            wr(a, d, 1'b0);
            chk("R10", "req after junk", int'(prog_req | erase_req), 0);
        end
        chk("R10", "busy after junk", int'(bank_busy), 0);
        rd(12'h123, 0, "R10");

        // R3 + R7: normal program in bank 0, reads during the window
        program4(12'h123, 16'hBEEF, 1'b0);
        chk("R3", "prog_req", int'(prog_req), 1);
        chk("R3", "prog_addr", int'(prog_addr), 'h123);
        chk("R3", "prog_data", int'(prog_data), 'hBEEF);
        chk("R3", "busy0 start", int'(bank_busy), 1);
        for (int i = 0; i < PC - 1; i++) begin
            rd(B1 | AW'($urandom % 2048), 0, "R7");
            rd(AW'($urandom % 2048), 2, "R7");
            @(negedge clk);
        end
        chk("R3", "busy0 last cycle", int'(bank_busy), 1);
        @(negedge clk);
        chk("R3", "busy0 done", int'(bank_busy), 0);

        // R10: broken second and third cycles
        wr(12'h555, 16'h00AA, 1'b0); wr(12'h2AA, 16'h0044, 1'b0);
        wr(12'h555, 16'h00A0, 1'b0); wr(12'h040, 16'h1234, 1'b0);
        chk("R10", "abort second", int'(prog_req | bank_busy), 0);
        unlock(12'h000); wr(12'h555, 16'h0077, 1'b0); wr(12'h041, 16'h0055, 1'b0);
        chk("R10", "abort third", int'(prog_req | erase_req | bank_busy), 0);

        // R8: identification mode in bank 1 only
        unlock(B1); wr(B1 | 12'h555, 16'h0090, 1'b0);
        rd(12'h9AB, 1, "R8"); rd(12'h100, 0, "R8");

        // R9: program to a bank in identification mode is ignored
        program4(12'h9AB, 16'h0101, 1'b0);
        chk("R9", "prog_req ident bank", int'(prog_req), 0);

        // R11: reset ignored while busy, effective afterwards
        program4(12'h200, 16'h0F0F, 1'b0);
        chk("R11", "busy0", int'(bank_busy), 1);
        wr(12'h000, 16'h00F0, 1'b0);
        rd(12'h9AB, 1, "R11");
        wait_idle(40);
        wr(12'h000, 16'h00F0, 1'b0);
        rd(12'h9AB, 0, "R11");

        // R4: bypass program path and exit
        unlock(12'h000); wr(12'h555, 16'h0020, 1'b0);
        chk("R4", "bypass_on", int'(bypass_on), 1);
        wr(12'h000, 16'h00A0, 1'b0); wr(12'h300, 16'hCAFE, 1'b0);
        chk("R4", "prog_req", int'(prog_req), 1);
        chk("R4", "prog_addr", int'(prog_addr), 'h300);
        wait_idle(40);
        wr(12'h000, 16'h0090, 1'b0); wr(12'h000, 16'h0000, 1'b0);
        chk("R4", "bypass after exit", int'(bypass_on), 0);
        wr(12'h000, 16'h00A0, 1'b0); wr(12'h301, 16'h0001, 1'b0);
        chk("R4", "two-cycle program after exit", int'(prog_req), 0);
        unlock(12'h000); wr(12'h555, 16'h0020, 1'b0); wr(12'h000, 16'h00F0, 1'b0);
        chk("R11", "reset leaves bypass", int'(bypass_on), 0);

        // R5: protection and acceleration
        program4(12'h400, 16'h1111, 1'b1);
        chk("R5", "protected ignored", int'(prog_req | bank_busy), 0);
        acc = 1'b1; #1;
        chk("R5", "bypass_on with acc", int'(bypass_on), 1);
        wr(12'h000, 16'h00A0, 1'b0); wr(12'h400, 16'h2222, 1'b1);
        chk("R5", "protected accepted", int'(prog_req), 1);
        chk("R5", "busy start", int'(bank_busy), 1);
        repeat (AC - 1) @(negedge clk);
        chk("R5", "busy last cycle", int'(bank_busy), 1);
        @(negedge clk);
        chk("R5", "busy done", int'(bank_busy), 0);
        acc = 1'b0; #1;
        chk("R5", "bypass_on released", int'(bypass_on), 0);

        // R6 + R2 + R12: sector erase in bank 1, suspend, nested program, resume
        erase_seq(12'hA37, 8'h30);
        chk("R6", "erase_req", int'(erase_req), 1);
        chk("R2", "erase_addr large", int'(erase_addr), exp_base(12'hA37));
        chk("R6", "erase_chip", int'(erase_chip), 0);
        chk("R6", "busy1", int'(bank_busy), 2);
        repeat (5) @(negedge clk);
        wr(B1, 16'h00B0, 1'b0);
        chk("R12", "suspended not busy", int'(bank_busy), 0);
        rd(12'hA10, 2, "R12"); rd(12'hC00, 0, "R12"); rd(12'h010, 0, "R12");
        program4(12'hA05, 16'h0505, 1'b0);
        chk("R12", "program erasing sector", int'(prog_req), 0);
        program4(12'hE00, 16'h3333, 1'b0);
        chk("R12", "program other sector", int'(prog_req), 1);
        chk("R12", "nested busy", int'(bank_busy), 2);
        repeat (PC) @(negedge clk);
        chk("R12", "nested done", int'(bank_busy), 0);
        rd(12'hA10, 2, "R12");
        wr(B1, 16'h0030, 1'b0);
        chk("R12", "resumed busy", int'(bank_busy), 2);
        wait_idle(EC);
        chk("R12", "resumed finished", int'(bank_busy), 0);
        rd(12'hA10, 0, "R12");

        // R6 + R2: sector erase in bank 0, exact window
        erase_seq(12'h07F, 8'h30);
        chk("R2", "erase_addr small", int'(erase_addr), exp_base(12'h07F));
        repeat (EC - 1) @(negedge clk);
        chk("R6", "erase last cycle", int'(bank_busy), 1);
        @(negedge clk);
        chk("R6", "erase done", int'(bank_busy), 0);

        // R6 + R12 + R9: whole-device erase
        erase_seq(12'h555, 8'h10);
        chk("R6", "whole erase_req", int'(erase_req), 1);
        chk("R6", "whole erase_chip", int'(erase_chip), 1);
        chk("R6", "whole busy", int'(bank_busy), 3);
        wr(12'h000, 16'h00B0, 1'b0);
        chk("R12", "no suspend on whole", int'(bank_busy), 3);
        program4(12'h010, 16'h7777, 1'b0);
        chk("R9", "program busy bank", int'(prog_req), 0);
        wait_idle(EC);
        @(negedge clk);
        chk("R6", "whole done", int'(bank_busy), 0);
        chk("R6", "erase_chip cleared", int'(erase_chip), 0);

        $display("  %0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

endmodule